// File: doc/BRIEF.md
# Filtered Quadrature Encoder Position Counter

This block turns the two phase channels of an incremental quadrature encoder into a signed position count. Both channels arrive asynchronously. Each one passes through a two-flop synchroniser and then a stability filter. The filter accepts a new level only after that level has held for a fixed number of clock cycles. The system clock must run at least ten times faster than the fastest encoder edge rate.

The two filtered channels drive a phase state machine. Each legal quarter-cycle step makes the machine emit one up pulse or one down pulse, and a wrapping signed counter accumulates these pulses. The block also reports the direction of the last valid step and a sticky flag. That flag records any jump in which both channels moved at once.

The named states are ST_WARM (start-up load), ST_P0 (A=0,B=0), ST_P1 (A=1,B=0), ST_P2 (A=1,B=1) and ST_P3 (A=0,B=1). The named transitions are:
- warm-up load: ST_WARM goes to the phase of the filtered inputs.
- forward step: P0 to P1, P1 to P2, P2 to P3, P3 to P0.
- reverse step: the forward steps in the opposite order.
- illegal jump: P0 with P2, or P1 with P3, in either direction.

Top module: `quad_pos_counter`

## Requirements
- R1: A forward step counts +1 on `position`. The forward order is ST_P0 (A=0,B=0) to ST_P1 (A=1,B=0) to ST_P2 (A=1,B=1) to ST_P3 (A=0,B=1) and back to ST_P0.
- R2: A reverse step, taking that order backwards, counts -1.
- R3: Each raw channel is synchronised through two flops and then filtered. A synchronised level that differs from the filter output for fewer than STABLE_CYCLES (default 4) consecutive clocks is ignored. With the defaults, a count appears on the 7th rising edge after the raw input changes.
- R4: When both filtered channels change in the same cycle, `position` stays unchanged and `jump_err` goes to 1. `jump_err` stays at 1 until reset. The state machine takes the observed phase, so the next step is counted from that phase.
- R5: `dir_up` is 1 after a forward step and 0 after a reverse step. Any other event leaves it unchanged.
- R6: `clear_count` sets `position` to 0 on the next edge. It takes priority over a step in the same cycle. It does not change `dir_up` or `jump_err`.
- R7: `position` is a CNT_W-bit two's-complement value that wraps from its maximum to its minimum, and from its minimum back to its maximum.
- R8: After reset, `position` is 0, `dir_up` is 0 and `jump_err` is 0. The machine loads the filtered phase of the inputs that are held during reset, and this load produces no count.
- R9: `position` changes by at most one per clock unless a clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ch_a_raw | input | 1 | Encoder channel A, asynchronous |
| ch_b_raw | input | 1 | Encoder channel B, asynchronous |
| clear_count | input | 1 | Synchronous clear of the position count |
| position | output | CNT_W | Signed position count |
| dir_up | output | 1 | 1 if the last valid step was forward |
| jump_err | output | 1 | Sticky flag for an illegal two-channel jump |

## Verification
On every cycle, the assertions check the following:
- `position` moves by at most one count.
- A clear lands on zero.
- A rise of `jump_err` leaves the count unchanged.
- `jump_err` stays set once it is set.
- A +1 change comes with `dir_up` high.
- The filter output moves only to the synchronised level.

The exact filter latency needs the bench's directed scenarios, and so does the rejection of a three-clock glitch. The same holds for wrap-around, resynchronisation after an illegal jump, and the absence of a count after a reset with both inputs high.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [2:0] {
        ST_WARM,
        ST_P0,
        ST_P1,
        ST_P2,
        ST_P3
    } qstate_t;

    // Map a filtered channel pair to its phase state.
    function automatic qstate_t phase_of(input logic a, input logic b);
        qstate_t s;
        unique case ({a, b})
            2'b00:   s = ST_P0;
            2'b10:   s = ST_P1;
            2'b11:   s = ST_P2;
            default: s = ST_P3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], din};
        end
    end

    assign dout = shreg[STAGES-1];
endmodule

// File: rtl/qenc_filter.sv
module qenc_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prime,
    input  logic din,
    output logic dout
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            run_len <= '0;
        end else if (prime) begin
            dout    <= din;
            run_len <= '0;
        end else if (din == dout) begin
            run_len <= '0;
        end else if (run_len == CW'(HOLD - 1)) begin
            dout    <= din;
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/qenc_phase_fsm.sv
module qenc_phase_fsm #(
    parameter int WARM = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fa,
    input  logic fb,
    output logic prime,
    output logic step_up,
    output logic step_dn,
    output logic dir_up,
    output logic jump_err
);
    import qenc_pkg::*;

    localparam int WW = $clog2(WARM + 1);

    qstate_t       state, nstate, obs, fwd_s, rev_s;
    logic [WW-1:0] warm;
    logic          warm_done;
    logic          bad;

    assign warm_done = (warm == WW'(WARM));
    assign prime     = (state == ST_WARM);
    assign obs       = phase_of(fa, fb);

    always_comb begin
        nstate  = state;
        fwd_s   = ST_WARM;
        rev_s   = ST_WARM;
        step_up = 1'b0;
        step_dn = 1'b0;
        bad     = 1'b0;
        unique case (state)
            ST_WARM: if (warm_done) nstate = obs;
            ST_P0: begin fwd_s = ST_P1; rev_s = ST_P3; end
            ST_P1: begin fwd_s = ST_P2; rev_s = ST_P0; end
            ST_P2: begin fwd_s = ST_P3; rev_s = ST_P1; end
            ST_P3: begin fwd_s = ST_P0; rev_s = ST_P2; end
            default: nstate = ST_WARM;
        endcase
        if (state != ST_WARM && obs != state) begin
            nstate  = obs;
            step_up = (obs == fwd_s);
            step_dn = (obs == rev_s);
            bad     = !(step_up || step_dn);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WARM;
            warm  <= '0;
        end else begin
            state <= nstate;
            if (state == ST_WARM && !warm_done) warm <= warm + 1'b1;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_up   <= 1'b0;
            jump_err <= 1'b0;
        end else begin
            if (step_up)      dir_up <= 1'b1;
            else if (step_dn) dir_up <= 1'b0;
            if (bad) jump_err <= 1'b1;
        end
    end
endmodule

// File: rtl/qenc_accum.sv
module qenc_accum #(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    up,
    input  logic                    dn,
    output logic signed [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  count <= '0;
        else if (clr) count <= '0;
        else if (up)  count <= count + 1'b1;
        else if (dn)  count <= count - 1'b1;
    end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
    parameter int CNT_W         = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ch_a_raw,
    input  logic                    ch_b_raw,
    input  logic                    clear_count,
    output logic signed [CNT_W-1:0] position,
    output logic                    dir_up,
    output logic                    jump_err
);
    localparam int NCH  = 2;
    localparam int WARM = SYNC_STAGES + 1;

    logic [NCH-1:0] raw_v, sync_v, filt_v;
    logic           prime, step_up, step_dn;
    logic           a_sync, a_filt;

    assign raw_v  = {ch_b_raw, ch_a_raw};
    assign a_sync = sync_v[0];
    assign a_filt = filt_v[0];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        qenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(raw_v[ch]), .dout(sync_v[ch])
        );
        qenc_filter #(.HOLD(STABLE_CYCLES)) u_filt (
            .clk(clk), .rst_n(rst_n), .prime(prime),
            .din(sync_v[ch]), .dout(filt_v[ch])
        );
    end

    qenc_phase_fsm #(.WARM(WARM)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fa(filt_v[0]), .fb(filt_v[1]),
        .prime(prime), .step_up(step_up), .step_dn(step_dn),
        .dir_up(dir_up), .jump_err(jump_err)
    );

    qenc_accum #(.CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clear_count),
        .up(step_up), .dn(step_dn), .count(position)
    );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clear_count,
    input logic signed [CNT_W-1:0] position,
    input logic                    dir_up,
    input logic                    jump_err,
    input logic                    a_sync,
    input logic                    a_filt
);
    assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_count |=> (position == $past(position)) ||
                         (position == $past(position) + CNT_W'(1)) ||
                         (position == $past(position) - CNT_W'(1)));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_count |=> position == '0);

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        jump_err |=> jump_err);

    assert_err_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_count && !jump_err) |=> (!jump_err || position == $past(position)));

    assert_dir_follows_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_count |=> ((position != $past(position) + CNT_W'(1)) ||
                          (position == $past(position)) || dir_up));

    assert_filter_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_filt != $past(a_filt)) |-> (a_filt == $past(a_sync)));
endmodule

bind quad_pos_counter qenc_checker #(.CNT_W(CNT_W)) u_qenc_chk (
    .clk(clk), .rst_n(rst_n), .clear_count(clear_count), .position(position),
    .dir_up(dir_up), .jump_err(jump_err), .a_sync(a_sync), .a_filt(a_filt)
);

// File: tb/test_quad_pos_counter.sv
`timescale 1ns/1ps
module test_quad_pos_counter;
    localparam int W    = 4;
    localparam int HOLD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ch_a = 1'b1, ch_b = 1'b1, clr = 1'b0;
    logic signed [W-1:0] pos;
    logic dir_up, jump_err;

    int checks = 0, failures = 0, exp_pos = 0, ph = 2;
    bit finished = 0;

    always #2.5 clk = ~clk;

    quad_pos_counter #(.CNT_W(W)) i_quad_pos_counter (
        .clk(clk), .rst_n(rst_n), .ch_a_raw(ch_a), .ch_b_raw(ch_b),
        .clear_count(clr), .position(pos), .dir_up(dir_up), .jump_err(jump_err)
    );

    function automatic int wrapw(input int v);
        logic signed [W-1:0] t;
        t = W'(v);
        return int'(t);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive_phase(input int p);
        ph = p & 3;
        ch_a = (ph == 1) || (ph == 2);
        ch_b = (ph == 2) || (ph == 3);
    endtask

    task automatic do_step(input bit fwd);
        drive_phase(fwd ? ph + 1 : ph + 3);
        exp_pos = wrapw(exp_pos + (fwd ? 1 : -1));
        wait_n(HOLD);
    endtask

    task automatic t_reset;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(20);
        chk("R8 position after reset", int'(pos), 0);
        chk("R8 dir after reset", int'(dir_up), 0);
        chk("R8 err after reset", int'(jump_err), 0);
    endtask

    task automatic t_latency;
        drive_phase(ph + 1);
        wait_n(6);
        chk("R3 no count before 7th edge", int'(pos), exp_pos);
        wait_n(1);
        exp_pos = wrapw(exp_pos + 1);
        chk("R3 R9 count on 7th edge", int'(pos), exp_pos);
        wait_n(HOLD);
    endtask

    task automatic t_forward;
        for (int i = 0; i < 4; i++) begin
            do_step(1'b1);
            chk("R1 forward step", int'(pos), exp_pos);
        end
        chk("R5 dir after forward", int'(dir_up), 1);
    endtask

    task automatic t_reverse;
        for (int i = 0; i < 6; i++) begin
            do_step(1'b0);
            chk("R2 reverse step", int'(pos), exp_pos);
        end
        chk("R5 dir after reverse", int'(dir_up), 0);
    endtask

    task automatic t_glitch;
        ch_a = ~ch_a;
        wait_n(3);
        ch_a = ~ch_a;
        wait_n(HOLD);
        chk("R3 A glitch ignored", int'(pos), exp_pos);
        ch_b = ~ch_b;
        wait_n(3);
        ch_b = ~ch_b;
        wait_n(HOLD);
        chk("R3 B glitch ignored", int'(pos), exp_pos);
        chk("R5 dir after glitch", int'(dir_up), 0);
    endtask

    task automatic t_clear;
        drive_phase(ph + 1);
        wait_n(5);
        clr = 1'b1;
        wait_n(3);
        clr = 1'b0;
        exp_pos = 0;
        wait_n(HOLD);
        chk("R6 clear wins over step", int'(pos), 0);
        chk("R6 dir kept by clear", int'(dir_up), 1);
        chk("R6 err kept by clear", int'(jump_err), 0);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 7; i++) do_step(1'b1);
        chk("R7 maximum reached", int'(pos), 7);
        do_step(1'b1);
        chk("R7 wrap to minimum", int'(pos), -8);
        do_step(1'b0);
        chk("R7 wrap back to maximum", int'(pos), 7);
    endtask

    task automatic t_illegal;
        drive_phase(ph + 2);
        wait_n(HOLD);
        chk("R4 count held on jump", int'(pos), exp_pos);
        chk("R4 err set", int'(jump_err), 1);
        chk("R5 dir kept on jump", int'(dir_up), 0);
        do_step(1'b1);
        chk("R4 resync then step", int'(pos), exp_pos);
        chk("R4 err sticky", int'(jump_err), 1);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_forward();
        t_reverse();
        t_glitch();
        t_clear();
        t_wrap();
        t_illegal();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule